// File: doc/BRIEF.md
# Datagram Header Parser and Endpoint Router

This block sits on the receive side of a host link and takes in a plain byte stream. The stream is cut into datagrams. Each datagram opens with a header of three unsigned variable-length integers: first the target endpoint number, then a count of returned credits, then the payload length. The payload bytes follow the header. The block decodes the header as it arrives. It then steers the payload bytes straight through to one of `NUM_EP` endpoint ports, without holding a datagram in any buffer, and it marks the final byte. Each endpoint port can stall the stream through its ready input.

Each header integer is stored in 7-bit groups, with the lowest group first. Bit 7 of a byte is set when at least one more byte of the same integer follows. Whenever a datagram returns a nonzero credit count, the block passes that count to the local transmit side as a one-cycle pulse.

Three kinds of datagram get special handling:
- A zero-length datagram that carries credits only returns those credits and is never delivered.
- A zero-length datagram with zero credits is a true empty datagram. It is delivered as a single end marker that carries no data.
- A datagram whose endpoint is not available is discarded as a whole, and the parser stays aligned on the next header.

Numbers that cannot fit, and endpoint numbers that do not exist, each set a sticky error flag.

Top module: `dgram_router`

## Requirements
- R1: Header integers are decoded with 7 data bits per byte, lowest group first. Bit 7 of a byte set means another byte of the same integer follows. Values up to `VAL_W` bits are supported, including redundant zero groups such as 0x82 0x00 for the value 2.
- R2: The header field order is endpoint, then credits, then length. The next `length` bytes are presented, one per handshake and in order, on the endpoint port numbered by the endpoint field, with `ep_data` equal to the input byte. `ep_last` is high on exactly the final payload byte.
- R3: When the credit field completes with a nonzero value, `cred_valid` pulses high for one cycle, one cycle after the final credit byte is accepted, with `cred_value` equal to the decoded value. A zero credit field produces no pulse.
- R4: A datagram with length 0 and nonzero credits raises no `ep_valid` on any port.
- R5: A datagram with length 0 and credits 0, addressed to an available endpoint, gives exactly one handshake on that port with `ep_nodata`=1 and `ep_last`=1. No input byte is consumed while that handshake is pending.
- R6: `ep_avail` of the target is sampled when the last length byte is accepted. If it is low, the whole datagram is consumed from the input without any `ep_valid`, and the following datagram is routed normally.
- R7: An endpoint number of `NUM_EP` or more, in a datagram that is not credit-only, has its payload consumed without delivery and sets `err_bad_ep`. The flag stays set until reset, and later datagrams are routed normally.
- R8: An integer whose final allowed byte (byte `ceil(VAL_W/7)`) has bit 7 set, or sets data bits above bit `VAL_W-1`, sets the sticky flag `err_overlong`. The parser then drops input bytes up to and including the next byte with bit 7 clear, and treats the byte after that as the start of a new header.
- R9: Payload stalls while the selected port's `ep_ready` is low. No byte is lost or repeated, and datagrams to the same endpoint are delivered in arrival order.
- R10: While reset (`rst_n`=0) is active and just after it, all `ep_valid` bits, `cred_valid`, `err_bad_ep` and `err_overlong` are 0, and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte |
| ep_valid | output | NUM_EP | Per-port valid for the routed byte or marker |
| ep_ready | input | NUM_EP | Per-port ready |
| ep_avail | input | NUM_EP | Per-port ability to take a whole datagram |
| ep_data | output | 8 | Routed payload byte (shared by all ports) |
| ep_last | output | 1 | Final item of the datagram |
| ep_nodata | output | 1 | Item is an empty-datagram marker with no data |
| cred_valid | output | 1 | Credit-return pulse |
| cred_value | output | VAL_W | Returned credit count |
| err_bad_ep | output | 1 | Sticky: endpoint number out of range |
| err_overlong | output | 1 | Sticky: header integer too long |

## Verification
On every cycle, the assertions check the following:
- at most one port is valid at a time;
- no credit pulse ever carries a zero count;
- a dropped datagram never drives a port;
- input is stalled while an empty marker is pending;
- both error flags stay set once raised;
- the integer decoder never runs past its last byte slot.

Other properties need traffic to show. The bench's behavioural model must drive multi-byte header encodings, credit-only and empty datagrams, unavailable and nonexistent endpoints, and resync after an overlong integer. Only under that traffic, with random stalls, can the bench confirm that routed bytes, end marks, ordering, credit values and framing after every discard match the requirements.

// File: rtl/dgram_pkg.sv
package dgram_pkg;
   typedef enum logic [2:0] {
      ST_EP    = 3'd0,
      ST_CRED  = 3'd1,
      ST_LEN   = 3'd2,
      ST_PAY   = 3'd3,
      ST_EMPTY = 3'd4,
      ST_SKIP  = 3'd5
   } dgram_state_e;
endpackage

// File: rtl/dgram_varint.sv
module dgram_varint #(
   parameter int VAL_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [7:0]       byte_in,
   output logic             done,
   output logic             overlong,
   output logic [VAL_W-1:0] value
);
   localparam int NBYTES   = (VAL_W + 6) / 7;
   localparam int IDX_W    = $clog2(NBYTES + 1);
   localparam int TOP_BITS = VAL_W - 7 * (NBYTES - 1);

   initial begin
      if (VAL_W < 8) $error("dgram_varint: VAL_W must be at least 8");
   end

   logic [VAL_W-1:0] acc_q;
   logic [IDX_W-1:0] idx_q;
   logic [VAL_W-1:0] grp;
   logic             last_slot;
   logic             top_bad;
   int unsigned      sh;

   generate
      if (TOP_BITS < 7) begin : g_top_check
         assign top_bad = |byte_in[6:TOP_BITS];
      end else begin : g_top_free
         assign top_bad = 1'b0;
      end
   endgenerate

   always_comb begin
      sh        = 7 * int'(idx_q);
      grp       = VAL_W'(byte_in[6:0]) << sh;
      value     = acc_q | grp;
      last_slot = (idx_q == IDX_W'(NBYTES - 1));
      overlong  = step && last_slot && (byte_in[7] || top_bad);
      done      = step && !byte_in[7] && !overlong;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         idx_q <= '0;
      end else if (step) begin
         if (done || overlong) begin
            acc_q <= '0;
            idx_q <= '0;
         end else begin
            acc_q <= value;
            idx_q <= idx_q + IDX_W'(1);
         end
      end
   end

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx_q) < NBYTES); // R8
endmodule

// File: rtl/dgram_route.sv
module dgram_route #(
   parameter int NUM_EP = 4,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fwd,
   input  logic [SEL_W-1:0]  sel,
   input  logic [NUM_EP-1:0] ep_ready,
   output logic [NUM_EP-1:0] ep_valid,
   output logic              sel_ready
);
   logic [NUM_EP-1:0] hit;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_EP; gi++) begin : g_port
         assign hit[gi]      = (sel == SEL_W'(gi));
         assign ep_valid[gi] = fwd && hit[gi];
      end
   endgenerate

   assign sel_ready = |(hit & ep_ready);

   AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ep_valid)); // R2
endmodule

// File: rtl/dgram_router.sv
module dgram_router
   import dgram_pkg::*;
#(
   parameter int NUM_EP = 4,
   parameter int VAL_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   output logic [NUM_EP-1:0] ep_valid,
   input  logic [NUM_EP-1:0] ep_ready,
   input  logic [NUM_EP-1:0] ep_avail,
   output logic [7:0]        ep_data,
   output logic              ep_last,
   output logic              ep_nodata,
   output logic              cred_valid,
   output logic [VAL_W-1:0]  cred_value,
   output logic              err_bad_ep,
   output logic              err_overlong
);
   localparam int SEL_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;

   initial begin
      if (NUM_EP < 1) $error("dgram_router: NUM_EP must be at least 1");
      if (VAL_W < 8 || VAL_W < SEL_W) $error("dgram_router: VAL_W too small");
   end

   dgram_state_e     state_q;
   logic [VAL_W-1:0] ep_q, cred_q, rem_q;
   logic             drop_q;
   logic             hdr, step, f_done, f_over, fwd, sel_ready;
   logic             in_range, avail_sel, target_ok;
   logic [VAL_W-1:0] f_val;
   logic [SEL_W-1:0] sel;

   assign hdr      = (state_q == ST_EP) || (state_q == ST_CRED) || (state_q == ST_LEN);
   assign step     = hdr && in_valid;
   assign sel      = ep_q[SEL_W-1:0];
   assign in_range = (ep_q < VAL_W'(NUM_EP));

   always_comb begin
      avail_sel = 1'b0;
      for (int i = 0; i < NUM_EP; i++)
         if (sel == SEL_W'(i)) avail_sel = ep_avail[i];
   end
   assign target_ok = in_range && avail_sel;

   dgram_varint #(.VAL_W(VAL_W)) u_varint (
      .clk(clk), .rst_n(rst_n), .step(step), .byte_in(in_data),
      .done(f_done), .overlong(f_over), .value(f_val)
   );

   assign fwd = ((state_q == ST_PAY) && in_valid && !drop_q) || (state_q == ST_EMPTY);

   dgram_route #(.NUM_EP(NUM_EP), .SEL_W(SEL_W)) u_route (
      .clk(clk), .rst_n(rst_n), .fwd(fwd), .sel(sel),
      .ep_ready(ep_ready), .ep_valid(ep_valid), .sel_ready(sel_ready)
   );

   always_comb begin
      unique case (state_q)
         ST_PAY:   in_ready = drop_q ? 1'b1 : sel_ready;
         ST_EMPTY: in_ready = 1'b0;
         default:  in_ready = 1'b1;
      endcase
   end

   assign ep_data   = (state_q == ST_PAY) ? in_data : 8'h00;
   assign ep_last   = ((state_q == ST_PAY) && (rem_q == VAL_W'(1))) || (state_q == ST_EMPTY);
   assign ep_nodata = (state_q == ST_EMPTY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_EP;
         ep_q         <= '0;
         cred_q       <= '0;
         rem_q        <= '0;
         drop_q       <= 1'b0;
         cred_valid   <= 1'b0;
         cred_value   <= '0;
         err_bad_ep   <= 1'b0;
         err_overlong <= 1'b0;
      end else begin
         cred_valid <= 1'b0;
         unique case (state_q)
            ST_EP, ST_CRED, ST_LEN: begin
               if (f_over) begin
                  err_overlong <= 1'b1;
                  state_q      <= in_data[7] ? ST_SKIP : ST_EP;
               end else if (f_done) begin
                  if (state_q == ST_EP) begin
                     ep_q    <= f_val;
                     state_q <= ST_CRED;
                  end else if (state_q == ST_CRED) begin
                     cred_q     <= f_val;
                     cred_valid <= (f_val != '0);
                     cred_value <= f_val;
                     state_q    <= ST_LEN;
                  end else if (f_val == '0) begin
                     if (cred_q != '0) begin
                        state_q <= ST_EP;
                     end else if (target_ok) begin
                        state_q <= ST_EMPTY;
                     end else begin
                        if (!in_range) err_bad_ep <= 1'b1;
                        state_q <= ST_EP;
                     end
                  end else begin
                     rem_q   <= f_val;
                     drop_q  <= !target_ok;
                     if (!in_range) err_bad_ep <= 1'b1;
                     state_q <= ST_PAY;
                  end
               end
            end
            ST_PAY: begin
               if (in_valid && in_ready) begin
                  rem_q <= rem_q - VAL_W'(1);
                  if (rem_q == VAL_W'(1)) begin
                     drop_q  <= 1'b0;
                     state_q <= ST_EP;
                  end
               end
            end
            ST_EMPTY: if (sel_ready) state_q <= ST_EP;
            ST_SKIP:  if (in_valid && !in_data[7]) state_q <= ST_EP;
            default:  state_q <= ST_EP;
         endcase
      end
   end

   AST_CRED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cred_valid |-> (cred_value != '0)); // R3
   AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_PAY) && drop_q) |-> (ep_valid == '0)); // R6
   AST_EMPTY_HOLDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      ep_nodata |-> !in_ready); // R5
   AST_BAD_EP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_bad_ep |=> err_bad_ep); // R7
   AST_OVERLONG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_overlong |=> err_overlong); // R8
endmodule

// File: tb/dgram_router_tb.sv
module dgram_router_tb;
   localparam int NUM_EP = 4;
   localparam int VAL_W  = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [7:0]        in_data = 8'h00;
   logic              in_ready;
   logic [NUM_EP-1:0] ep_valid;
   logic [NUM_EP-1:0] ep_ready = '0;
   logic [NUM_EP-1:0] ep_avail = '1;
   logic [7:0]        ep_data;
   logic              ep_last, ep_nodata, cred_valid, err_bad_ep, err_overlong;
   logic [VAL_W-1:0]  cred_value;

   dgram_router #(.NUM_EP(NUM_EP), .VAL_W(VAL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .ep_valid(ep_valid), .ep_ready(ep_ready),
      .ep_avail(ep_avail), .ep_data(ep_data), .ep_last(ep_last),
      .ep_nodata(ep_nodata), .cred_valid(cred_valid), .cred_value(cred_value),
      .err_bad_ep(err_bad_ep), .err_overlong(err_overlong)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   bit run    = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   logic [7:0] byte_q[$];
   int         exp_q[NUM_EP][$];
   longint     cred_q[$];

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic push_leb(longint unsigned v);
      logic [7:0] b;
      do begin
         b = 8'(v & 64'h7F);
         v = v >> 7;
         if (v != 0) b[7] = 1'b1;
         byte_q.push_back(b);
      end while (v != 0);
   endtask

   task automatic wait_drain();
      while (byte_q.size() != 0) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic send_dg(int ep, longint cred, int len, bit avail, int seed);
      wait_drain();
      if (ep < NUM_EP) ep_avail[ep] = avail;
      push_leb(longint'(ep));
      push_leb(cred);
      push_leb(longint'(len));
      for (int k = 0; k < len; k++) byte_q.push_back(8'((seed + 7 * k) & 255));
      if (cred != 0) cred_q.push_back(cred);
      if (ep < NUM_EP && avail && !(len == 0 && cred != 0)) begin
         if (len == 0) exp_q[ep].push_back(32'h300);
         for (int k = 0; k < len; k++)
            exp_q[ep].push_back(((k == len - 1) ? 32'h100 : 0) | ((seed + 7 * k) & 255));
      end
   endtask

   // Reference comparison on every clock
   initial begin
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (run) begin
            for (int i = 0; i < NUM_EP; i++) ep_ready[i] = lfsr[i] | lfsr[i + 4];
            in_valid = (byte_q.size() != 0) && (lfsr[9] | lfsr[11]);
            in_data  = (byte_q.size() != 0) ? byte_q[0] : 8'h00;
         end
         #1;
         if (run) begin
            for (int i = 0; i < NUM_EP; i++) begin
               if (ep_valid[i] && ep_ready[i]) begin
                  int got;
                  got = {ep_nodata, ep_last, ep_data};
                  if (exp_q[i].size() == 0) check(1'b0, "R2 R4 R6 R7 unexpected item", got, -1);
                  else begin
                     int e;
                     e = exp_q[i].pop_front();
                     check(got == e, "R2 R5 R9 routed item", got, e);
                  end
               end
            end
            if (cred_valid) begin
               if (cred_q.size() == 0) check(1'b0, "R3 unexpected credit", cred_value, 0);
               else begin
                  longint c;
                  c = cred_q.pop_front();
                  check(longint'(cred_value) == c, "R3 R1 credit value", cred_value, c);
               end
            end
            if (in_valid && in_ready) void'(byte_q.pop_front());
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(ep_valid == '0 && !cred_valid, "R10 idle outputs", {ep_valid, cred_valid}, 0);
      check(!err_bad_ep && !err_overlong, "R10 flags clear", {err_bad_ep, err_overlong}, 0);
      check(in_ready, "R10 in_ready", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(ep_valid == '0 && !cred_valid && in_ready, "R10 after reset", {ep_valid, cred_valid, in_ready}, 1);
      run = 1'b1;

      send_dg(1, 0, 5, 1, 16);            // R2 basic
      send_dg(2, 300, 200, 1, 3);          // R1 multi-byte length/credit
      send_dg(0, 5, 0, 1, 0);              // R4 credit-only
      send_dg(3, 0, 0, 1, 0);              // R5 empty datagram
      send_dg(2, 0, 6, 0, 40);             // R6 unavailable, dropped
      send_dg(2, 1, 4, 1, 90);             // R6 framing kept
      send_dg(1, 0, 3, 1, 11);             // R9 order on same port
      send_dg(1, 0, 1, 1, 200);            // R9
      wait_drain();
      check(!err_bad_ep && !err_overlong, "R7 R8 no spurious error", {err_bad_ep, err_overlong}, 0);
      // R1 redundant zero group: endpoint 2 as 0x82 0x00
      byte_q.push_back(8'h82); byte_q.push_back(8'h00);
      byte_q.push_back(8'h00); byte_q.push_back(8'h01); byte_q.push_back(8'h5A);
      exp_q[2].push_back(32'h15A);
      // R1 max value credit 0xFFFFFFFF
      send_dg(0, 64'hFFFF_FFFF, 2, 1, 77);
      send_dg(9, 0, 4, 1, 1);              // R7 bad endpoint
      wait_drain();
      repeat (2) @(negedge clk);
      check(err_bad_ep, "R7 bad endpoint flag", err_bad_ep, 1);
      send_dg(3, 0, 2, 1, 60);             // R7 framing after bad endpoint
      // R8 overlong by continuation then resync
      wait_drain();
      repeat (5) byte_q.push_back(8'hFF);
      byte_q.push_back(8'h81); byte_q.push_back(8'h01);
      send_dg(0, 0, 3, 1, 120);
      wait_drain();
      repeat (2) @(negedge clk);
      check(err_overlong, "R8 overlong flag", err_overlong, 1);
      // R8 overlong by excess bits in final byte, terminates field
      byte_q.push_back(8'h80); byte_q.push_back(8'h80); byte_q.push_back(8'h80);
      byte_q.push_back(8'h80); byte_q.push_back(8'h10);
      send_dg(2, 2, 3, 1, 33);
      send_dg(3, 0, 0, 1, 0);              // R5 again
      wait_drain();
      repeat (400) @(negedge clk);
      for (int i = 0; i < NUM_EP; i++)
         check(exp_q[i].size() == 0, "R2 R9 all items delivered", exp_q[i].size(), 0);
      check(cred_q.size() == 0, "R3 all credits seen", cred_q.size(), 0);
      check(err_bad_ep && err_overlong, "R7 R8 flags sticky", {err_bad_ep, err_overlong}, 3);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule